// File: doc/BRIEF.md
# HDLC Bit-Stream Receive Deframer

This block sits behind a line decoder and turns a stream of plain NRZ bits into HDLC/SDLC frames. Each bit arrives on `bit_in` together with a one-cycle qualifier `bit_en`. The block finds opening and closing flags and removes the zeros that the sender stuffed after runs of five ones. It recognises aborts, go-ahead patterns and an idle line. Characters are assembled least significant bit first, and the frame check sequence is verified over every frame.

The receiver holds back the last sixteen bits of every frame, so that the check sequence is never delivered as data. The final data character is released in the same cycle as the end-of-frame strobe. An optional station-address filter compares the first character of each frame against `station_addr` and discards frames addressed elsewhere. The all-ones global address always passes. When extended addressing is on, the address field runs on until a character with its lowest bit set, and every character of that field is tagged.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, `chr_vld`, `eof_vld`, `eof_crc_ok`, `abort_pulse`, `ga_pulse` and `line_idle` are all low.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed from the data and is not included in the check sequence. Data containing 0xFF, 0x7E and 0xF8 is delivered unchanged.
- R3: The pattern 01111110 opens and closes a frame. Characters are delivered on one-cycle `chr_vld` pulses, with the first received bit in `chr_data[0]`. The two check-sequence characters are never delivered. Each output pulse comes one clock after the `bit_en` cycle that causes it.
- R4: The check sequence uses the generator x^16+x^12+x^5+1 with the register preset to all ones, fed least significant bit first. It is sent complemented, low byte first. A frame received intact ends with `eof_vld` and `eof_crc_ok` both high, which corresponds to the residue 0xF0B8.
- R5: A frame whose content was altered still ends with `eof_vld`, but `eof_crc_ok` is low.
- R6: A frame of fewer than 32 bits between flags gives no character and no end-of-frame strobe.
- R7: If a seventh consecutive 1 arrives after frame data, `abort_pulse` pulses once. The frame is dropped: no end-of-frame strobe follows.
- R8: If seven 1s follow directly on a flag's closing 0 (a go-ahead), `ga_pulse` pulses and `abort_pulse` stays low.
- R9: `line_idle` is high while the most recent 15 or more bits were all 1. It is low after 14 ones and falls when a 0 arrives.
- R10: With `filt_en` high, a frame whose first character is neither `station_addr` nor 0xFF yields no characters and no end-of-frame strobe.
- R11: With `filt_en` high, a frame whose first character matches `station_addr` or equals 0xFF is delivered in full, address character included.
- R12: With `filt_en` low, every frame is delivered regardless of its address.
- R13: `chr_addr` marks the first character of every frame. With `ext_addr_en` high, following characters are also marked, up to and including the first one whose bit 0 is 1. With `ext_addr_en` low, only the first character is marked.
- R14: For a frame whose length is a whole number of bytes, the final data character and `eof_vld` appear in the same cycle. For a frame whose length is not a whole number of bytes, `eof_vld` pulses with `eof_crc_ok` low and no final character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Received NRZ data bit |
| filt_en | input | 1 | Enables station-address filtering |
| ext_addr_en | input | 1 | Enables multi-character address field |
| station_addr | input | 8 | Address this station answers to |
| chr_vld | output | 1 | Pulse: a received character is on `chr_data` |
| chr_data | output | 8 | Received character, first bit in bit 0 |
| chr_addr | output | 1 | Character belongs to the address field |
| eof_vld | output | 1 | Pulse: a frame closed |
| eof_crc_ok | output | 1 | Frame check passed (valid with `eof_vld`) |
| abort_pulse | output | 1 | Pulse: frame aborted |
| ga_pulse | output | 1 | Pulse: go-ahead pattern seen |
| line_idle | output | 1 | Line has carried 15 or more ones in a row |

## Verification
The closing flag does two things in one cycle: it releases the last held-back data character and it raises the end-of-frame strobe with the check result. Every directed frame ends with that flag, and the bench records whether `chr_vld` was high in the very cycle `eof_vld` rose. It then compares the character delivered there against the last data byte it sent. A frame padded with three extra bits provokes the opposite case. There the strobe must come alone, with the check flagged bad.

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int MIN_FRAME_BITS = 32,
  parameter logic [15:0] CRC_POLY = 16'h8408,
  parameter logic [15:0] CRC_GOOD = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       filt_en,
  input  logic       ext_addr_en,
  input  logic [7:0] station_addr,
  output logic       chr_vld,
  output logic [7:0] chr_data,
  output logic       chr_addr,
  output logic       eof_vld,
  output logic       eof_crc_ok,
  output logic       abort_pulse,
  output logic       ga_pulse,
  output logic       line_idle
);
  localparam int FLAG_LEAD = 6;
  localparam int REL_MIN   = MIN_FRAME_BITS + FLAG_LEAD;
  localparam int CNT_W     = $clog2(REL_MIN + 1);
  localparam int SR_W      = REL_MIN - 1;
  localparam int CRC_TAP   = SR_W - FLAG_LEAD;
  localparam int FIN_LO    = SR_W - 30;

  logic [3:0]       ones_q;
  logic             open_q, seen0_q, drop_q, in_addr_q, first_q;
  logic [2:0]       nlo_q;
  logic [CNT_W-1:0] nsat_q;
  logic [SR_W-1:0]  sr_q;
  logic [15:0]      crc_q;

  logic             take, flag_hit, seventh, has_data, abort_hit, ga_hit;
  logic [CNT_W-1:0] nsat_nx;
  logic [2:0]       nlo_nx;
  logic             rel, closing, aligned, cand_v, mismatch, drop_eff;
  logic [7:0]       cand_b;
  logic             fb;
  logic [15:0]      crc_nx;

  assign take      = bit_en && open_q && (ones_q < 4'd5);
  assign flag_hit  = bit_en && !bit_in && (ones_q == 4'd6);
  assign seventh   = bit_en &&  bit_in && (ones_q == 4'd6);
  assign has_data  = open_q && (nsat_q > CNT_W'(5));
  assign abort_hit = seventh && has_data;
  assign ga_hit    = seventh && seen0_q && !has_data;

  assign nsat_nx = (nsat_q == CNT_W'(REL_MIN)) ? nsat_q : nsat_q + 1'b1;
  assign nlo_nx  = nlo_q + 3'd1;
  assign rel     = take && (nsat_nx == CNT_W'(REL_MIN)) && (nlo_nx == 3'd6);
  assign closing = flag_hit && open_q && (nsat_q == CNT_W'(REL_MIN));
  assign aligned = (nlo_q == 3'd6);

  assign cand_v   = rel || (closing && aligned);
  assign cand_b   = rel ? sr_q[7:0] : sr_q[FIN_LO+7:FIN_LO];
  assign mismatch = filt_en && (cand_b != station_addr) && (cand_b != 8'hFF);
  assign drop_eff = drop_q || (cand_v && first_q && mismatch);

  assign fb     = crc_q[0] ^ sr_q[CRC_TAP];
  assign crc_nx = (crc_q >> 1) ^ (fb ? CRC_POLY : 16'h0000);

  assign line_idle = (ones_q == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q    <= '0;
      open_q    <= 1'b0;
      seen0_q   <= 1'b0;
      drop_q    <= 1'b0;
      in_addr_q <= 1'b0;
      first_q   <= 1'b0;
      nlo_q     <= '0;
      nsat_q    <= '0;
      sr_q      <= '0;
      crc_q     <= '1;
    end else if (bit_en) begin
      if (bit_in) ones_q <= (ones_q == 4'd15) ? ones_q : ones_q + 4'd1;
      else        ones_q <= '0;
      if (!bit_in) seen0_q <= 1'b1;

      if (flag_hit) begin
        open_q    <= 1'b1;
        drop_q    <= 1'b0;
        in_addr_q <= 1'b1;
        first_q   <= 1'b1;
        nlo_q     <= '0;
        nsat_q    <= '0;
        crc_q     <= '1;
      end else if (seventh) begin
        open_q <= 1'b0;
      end else if (take) begin
        nlo_q  <= nlo_nx;
        nsat_q <= nsat_nx;
        sr_q   <= {bit_in, sr_q[SR_W-1:1]};
        if (nsat_nx >= CNT_W'(FLAG_LEAD + 1)) crc_q <= crc_nx;
        if (rel) begin
          drop_q  <= drop_eff;
          first_q <= 1'b0;
          if (in_addr_q) in_addr_q <= ext_addr_en && !cand_b[0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chr_vld     <= 1'b0;
      chr_data    <= '0;
      chr_addr    <= 1'b0;
      eof_vld     <= 1'b0;
      eof_crc_ok  <= 1'b0;
      abort_pulse <= 1'b0;
      ga_pulse    <= 1'b0;
    end else begin
      chr_vld     <= cand_v && !drop_eff;
      if (cand_v) begin
        chr_data <= cand_b;
        chr_addr <= in_addr_q;
      end
      eof_vld     <= closing && !drop_eff;
      eof_crc_ok  <= closing && !drop_eff && aligned && (crc_q == CRC_GOOD);
      abort_pulse <= abort_hit;
      ga_pulse    <= ga_hit;
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic chr_vld,
  input logic eof_vld,
  input logic eof_crc_ok,
  input logic abort_pulse,
  input logic ga_pulse,
  input logic line_idle
);
  p_ok_with_eof_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eof_crc_ok |-> eof_vld);
  p_eof_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eof_vld |=> !eof_vld);
  p_chr_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_vld |=> !chr_vld);
  p_no_bit_no_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !chr_vld && !eof_vld && !abort_pulse && !ga_pulse);
  p_abort_ga_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({abort_pulse, ga_pulse, eof_vld}));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_idle |-> !chr_vld && !eof_vld);
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .chr_vld(chr_vld),
  .eof_vld(eof_vld), .eof_crc_ok(eof_crc_ok), .abort_pulse(abort_pulse),
  .ga_pulse(ga_pulse), .line_idle(line_idle)
);

// File: tb/hdlc_rx_deframer_tb.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, bit_in = 1'b0, filt_en = 1'b0, ext_addr_en = 1'b0;
  logic [7:0] station_addr = 8'h00;
  logic chr_vld, chr_addr, eof_vld, eof_crc_ok, abort_pulse, ga_pulse, line_idle;
  logic [7:0] chr_data;

  always #10 clk = ~clk;

  hdlc_rx_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .filt_en(filt_en), .ext_addr_en(ext_addr_en), .station_addr(station_addr),
    .chr_vld(chr_vld), .chr_data(chr_data), .chr_addr(chr_addr),
    .eof_vld(eof_vld), .eof_crc_ok(eof_crc_ok), .abort_pulse(abort_pulse),
    .ga_pulse(ga_pulse), .line_idle(line_idle)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int tx_ones = 0;

  logic [7:0] log_chr [64];
  logic       log_adr [64];
  int nchr, neof, nabort, nga;
  logic last_ok, eof_with_chr;
  logic [7:0] eof_chr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (chr_vld && nchr < 64) begin
        log_chr[nchr] = chr_data;
        log_adr[nchr] = chr_addr;
        nchr++;
      end
      if (eof_vld) begin
        neof++;
        last_ok = eof_crc_ok;
        eof_with_chr = chr_vld;
        eof_chr = chr_data;
      end
      if (abort_pulse) nabort++;
      if (ga_pulse) nga++;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    nchr = 0; neof = 0; nabort = 0; nga = 0;
    last_ok = 1'b0; eof_with_chr = 1'b0; eof_chr = 8'h00;
  endtask

  task automatic raw_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
  endtask

  task automatic stop_bits();
    @(negedge clk);
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic stuffed_bit(input logic b);
    raw_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        raw_bit(1'b0);
        tx_ones = 0;
      end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) stuffed_bit(v[i]);
  endtask

  task automatic send_flag();
    raw_bit(1'b0);
    for (int i = 0; i < 6; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    tx_ones = 0;
  endtask

  function automatic logic [15:0] fcs_of(input logic [7:0] d [16], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        logic f = c[0] ^ d[k][i];
        c = c >> 1;
        if (f) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  // sends flag, n bytes, FCS (optionally corrupted data), extra bits, flag
  task automatic send_frame(input logic [7:0] d [16], input int n,
                            input bit corrupt, input int extra);
    logic [15:0] f = fcs_of(d, n);
    clear_log();
    send_flag();
    for (int k = 0; k < n; k++) send_byte((corrupt && k == n - 1) ? d[k] ^ 8'h04 : d[k]);
    send_byte(f[7:0]);
    send_byte(f[15:8]);
    for (int i = 0; i < extra; i++) stuffed_bit(i[0]);
    send_flag();
    stop_bits();
  endtask

  task automatic expect_data(input logic [7:0] d [16], input int n, input string tag);
    chk(nchr, n, {tag, " char count"});
    for (int k = 0; k < n && k < nchr; k++) chk(log_chr[k], d[k], {tag, " char value"});
  endtask

  task automatic t_reset();
    chk(chr_vld, 0, "R1 chr_vld");
    chk(eof_vld, 0, "R1 eof_vld");
    chk(eof_crc_ok, 0, "R1 eof_crc_ok");
    chk(abort_pulse, 0, "R1 abort");
    chk(ga_pulse, 0, "R1 ga");
    chk(line_idle, 0, "R1 line_idle");
  endtask

  task automatic t_basic();
    logic [7:0] d [16];
    d[0] = 8'h03; d[1] = 8'h11; d[2] = 8'h7E; d[3] = 8'hFF; d[4] = 8'hF8;
    filt_en = 1'b0; ext_addr_en = 1'b0;
    send_frame(d, 5, 1'b0, 0);
    expect_data(d, 5, "R2 R3 R12");
    chk(neof, 1, "R3 eof count");
    chk(last_ok, 1, "R4 crc good");
    chk(eof_with_chr, 1, "R14 last char with eof");
    chk(eof_chr, 8'hF8, "R14 last char value");
    chk(nabort, 0, "R3 no abort");
  endtask

  task automatic t_corrupt();
    logic [7:0] d [16];
    d[0] = 8'hA5; d[1] = 8'h5A; d[2] = 8'h3C;
    send_frame(d, 3, 1'b1, 0);
    chk(neof, 1, "R5 eof count");
    chk(last_ok, 0, "R5 crc bad");
  endtask

  task automatic t_short();
    logic [7:0] d [16];
    d[0] = 8'h01;
    send_frame(d, 1, 1'b0, 0);
    chk(nchr, 0, "R6 no chars");
    chk(neof, 0, "R6 no eof");
  endtask

  task automatic t_abort();
    clear_log();
    send_flag();
    send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
    for (int i = 0; i < 8; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    send_flag();
    stop_bits();
    chk(nabort, 1, "R7 abort pulse");
    chk(neof, 0, "R7 no eof");
    chk(nchr, 0, "R7 no chars");
  endtask

  task automatic t_ga();
    clear_log();
    send_flag();
    for (int i = 0; i < 7; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    stop_bits();
    chk(nga, 1, "R8 go-ahead pulse");
    chk(nabort, 0, "R8 no abort");
  endtask

  task automatic t_idle();
    raw_bit(1'b0);
    for (int i = 0; i < 14; i++) raw_bit(1'b1);
    @(negedge clk); bit_en = 1'b0;
    chk(line_idle, 0, "R9 14 ones not idle");
    raw_bit(1'b1);
    @(negedge clk); bit_en = 1'b0;
    chk(line_idle, 1, "R9 15 ones idle");
    raw_bit(1'b0);
    @(negedge clk); bit_en = 1'b0;
    chk(line_idle, 0, "R9 zero leaves idle");
  endtask

  task automatic t_filter();
    logic [7:0] d [16];
    d[0] = 8'h03; d[1] = 8'h44; d[2] = 8'h99;
    filt_en = 1'b1; station_addr = 8'h55;
    send_frame(d, 3, 1'b0, 0);
    chr_clear_check: begin
      chk(nchr, 0, "R10 mismatch no chars");
      chk(neof, 0, "R10 mismatch no eof");
    end
    d[0] = 8'h55;
    send_frame(d, 3, 1'b0, 0);
    expect_data(d, 3, "R11 match");
    chk(neof, 1, "R11 match eof");
    d[0] = 8'hFF;
    send_frame(d, 3, 1'b0, 0);
    expect_data(d, 3, "R11 global");
    chk(last_ok, 1, "R11 global crc");
    filt_en = 1'b0;
  endtask

  task automatic t_ext();
    logic [7:0] d [16];
    d[0] = 8'h02; d[1] = 8'h04; d[2] = 8'h07; d[3] = 8'h10; d[4] = 8'h20;
    ext_addr_en = 1'b1;
    send_frame(d, 5, 1'b0, 0);
    chk(nchr, 5, "R13 ext count");
    chk(log_adr[0], 1, "R13 ext a0"); chk(log_adr[1], 1, "R13 ext a1");
    chk(log_adr[2], 1, "R13 ext a2"); chk(log_adr[3], 0, "R13 ext d0");
    chk(log_adr[4], 0, "R13 ext d1");
    ext_addr_en = 1'b0;
    send_frame(d, 5, 1'b0, 0);
    chk(log_adr[0], 1, "R13 plain a0"); chk(log_adr[1], 0, "R13 plain d0");
  endtask

  task automatic t_misaligned();
    logic [7:0] d [16];
    d[0] = 8'h0F; d[1] = 8'h21; d[2] = 8'h43; d[3] = 8'h65; d[4] = 8'h87;
    send_frame(d, 5, 1'b0, 3);
    chk(neof, 1, "R14 misaligned eof");
    chk(last_ok, 0, "R14 misaligned crc bad");
    chk(eof_with_chr, 0, "R14 misaligned no final char");
  endtask

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_corrupt();
    t_short();
    t_abort();
    t_ga();
    t_idle();
    t_filter();
    t_ext();
    t_misaligned();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule